// File: doc/BRIEF.md
# Program Memory Read-Partition Guard

This block sits between a processor core and its program flash. It splits a 17-bit program address space into two regions at a boundary set by a write-once 8-bit limit register. The limit forms address bits 16..9, and the low nine bits are zero, so the boundary always lands on a 512-byte page edge. Addresses below the boundary form the protected region. Addresses at or above it form the open region.

For every data read of program memory, the guard looks at two addresses: the program counter of the instruction making the request, and the target address. When code in the open region tries to read a byte in the protected region, the guard returns a fixed masked byte in place of the stored byte and raises a one-cycle violation pulse. Write and erase requests are gated by the same rule: a blocked request gets no grant and is flagged in the same way. Instruction fetches pass through untouched in every case, so open-region code can still call entry points in the protected region.

The limit register takes the first write after a reset, and that write locks it. A lock bit shows software that this has happened. With the reset value of zero, nothing is protected.

Top module: `pmem_partition_guard`

## Requirements
- R1: After reset the limit value is 0x00, the lock bit is 0, and the read-valid, violation and program-grant outputs are all 0.
- R2: While the guard is unlocked, asserting limWrEn loads limWrData into the limit on that clock edge. From the next cycle, limValue shows the written value and limLocked is 1.
- R3: Once the guard is locked, every further limit write is ignored and limValue does not change. After a new reset, the next write is accepted again.
- R4: An address is in the protected region exactly when it is below limValue×512. Address limValue×512−1 is protected and address limValue×512 is open, for both the program counter and the target.
- R5: A data read (rdFetch=0) whose reqPc is in the open region and whose rdAddr is in the protected region returns 0x00 on rdData and sets accessViol high for that one result cycle.
- R6: A data read whose reqPc is in the protected region returns memRdData unchanged for any rdAddr, with accessViol 0.
- R7: A data read whose reqPc and rdAddr are both in the open region returns memRdData unchanged, with accessViol 0.
- R8: An instruction fetch (rdFetch=1) always returns memRdData unchanged with accessViol 0, whatever the two addresses are.
- R9: rdData and rdValid appear one cycle after rdReq, and rdValid is high for exactly one cycle per request cycle.
- R10: A program request (pgmReq) gives pgmGrant=1 one cycle later, unless reqPc is in the open region and pgmAddr is in the protected region. In that case pgmGrant is 0 and accessViol is 1 in that cycle.
- R11: With the limit at 0x00, every data read from any program counter returns memRdData with no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| limWrEn | input | 1 | Limit register write strobe |
| limWrData | input | 8 | Value for the limit register (address bits 16..9) |
| limValue | output | 8 | Current limit register contents |
| limLocked | output | 1 | Limit has been written since the last reset |
| reqPc | input | 17 | Program counter of the instruction making the request |
| rdReq | input | 1 | Program memory read request |
| rdFetch | input | 1 | 1 = instruction fetch, 0 = data read |
| rdAddr | input | 17 | Target address of the read |
| memRdData | input | 8 | Byte from the flash array for rdAddr, same cycle |
| rdData | output | 8 | Returned byte, registered |
| rdValid | output | 1 | rdData holds the result of the previous cycle's request |
| pgmReq | input | 1 | Write or erase request |
| pgmAddr | input | 17 | Target address of the write or erase |
| pgmGrant | output | 1 | Write or erase may proceed |
| accessViol | output | 1 | One-cycle pulse on a blocked read or program request |

## Verification
A wrong lock state shows on limLocked and limValue in the cycle after the limit write that should, or should not, have taken effect. A comparator that is off by one page shows only at a region edge, so the bench probes the addresses on each side of limValue×512 for every limit it tries. A wrong masking or grant decision shows in the very next cycle on rdData, pgmGrant and accessViol. The bench sweeps a grid of program counter pages and target pages under several limits and predicts each result from the page arithmetic.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;

  // Strobes from the decision logic to the datapath, valid for one cycle.
  typedef struct packed {
    logic loadLimit;  // copy limWrData into the limit register
    logic capture;    // register a read result this cycle
    logic maskData;   // substitute the masked byte for the flash byte
    logic readViol;   // blocked data read
    logic pgmPass;    // grant a program request
    logic pgmBlock;   // blocked program request
  } guardStrobes_t;

endpackage

// File: rtl/pmem_guard_dp.sv
module pmem_guard_dp
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LIMIT_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MASK_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strb,
  input  logic [LIMIT_W-1:0] limWrData,
  input  logic [ADDR_W-1:0] reqPc,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] pgmAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [LIMIT_W-1:0] limValue,
  output logic              pcLow,
  output logic              rdLow,
  output logic              pgmLow,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              accessViol,
  output logic              pgmGrant
);

  localparam int PAGE_W = ADDR_W - LIMIT_W;
  localparam int N_PROBE = 3;

  logic [LIMIT_W-1:0] limReg;
  logic [ADDR_W-1:0]  boundary;
  logic [N_PROBE-1:0][ADDR_W-1:0] probe;
  logic [N_PROBE-1:0] below;

  always_ff @(posedge clk) begin
    if (!rstN) limReg <= '0;
    else if (strb.loadLimit) limReg <= limWrData;
  end

  assign boundary = {limReg, {PAGE_W{1'b0}}};
  assign probe    = {pgmAddr, rdAddr, reqPc};

  // One magnitude comparator per address that needs classifying.
  for (genvar i = 0; i < N_PROBE; i++) begin : g_cmp
    assign below[i] = probe[i] < boundary;
  end

  assign pcLow  = below[0];
  assign rdLow  = below[1];
  assign pgmLow = below[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      rdValid    <= 1'b0;
      accessViol <= 1'b0;
      pgmGrant   <= 1'b0;
    end else begin
      rdValid    <= strb.capture;
      accessViol <= strb.readViol | strb.pgmBlock;
      pgmGrant   <= strb.pgmPass;
      if (strb.capture) rdData <= strb.maskData ? MASK_VAL : memRdData;
    end
  end

  assign limValue = limReg;

endmodule

// File: rtl/pmem_guard_ctrl.sv
module pmem_guard_ctrl
  import pmem_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          limWrEn,
  input  logic          rdReq,
  input  logic          rdFetch,
  input  logic          pgmReq,
  input  logic          pcLow,
  input  logic          rdLow,
  input  logic          pgmLow,
  output guardStrobes_t strb,
  output logic          limLocked
);

  logic lockedQ;
  logic pcHigh;
  logic readTrip;
  logic pgmTrip;

  always_ff @(posedge clk) begin
    if (!rstN) lockedQ <= 1'b0;
    else if (limWrEn) lockedQ <= 1'b1;
  end

  assign pcHigh   = ~pcLow;
  assign readTrip = rdReq & ~rdFetch & pcHigh & rdLow;
  assign pgmTrip  = pgmReq & pcHigh & pgmLow;

  always_comb begin
    strb           = '0;
    strb.loadLimit = limWrEn & ~lockedQ;
    strb.capture   = rdReq;
    strb.maskData  = readTrip;
    strb.readViol  = readTrip;
    strb.pgmPass   = pgmReq & ~pgmTrip;
    strb.pgmBlock  = pgmTrip;
  end

  assign limLocked = lockedQ;

endmodule

// File: rtl/pmem_partition_guard.sv
module pmem_partition_guard
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LIMIT_W = 8,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               limWrEn,
  input  logic [LIMIT_W-1:0] limWrData,
  output logic [LIMIT_W-1:0] limValue,
  output logic               limLocked,
  input  logic [ADDR_W-1:0]  reqPc,
  input  logic               rdReq,
  input  logic               rdFetch,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  input  logic               pgmReq,
  input  logic [ADDR_W-1:0]  pgmAddr,
  output logic               pgmGrant,
  output logic               accessViol
);

  guardStrobes_t strb;
  logic pcLow, rdLow, pgmLow;

  pmem_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .limWrEn(limWrEn), .rdReq(rdReq),
    .rdFetch(rdFetch), .pgmReq(pgmReq), .pcLow(pcLow), .rdLow(rdLow),
    .pgmLow(pgmLow), .strb(strb), .limLocked(limLocked)
  );

  pmem_guard_dp #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .DATA_W(DATA_W), .MASK_VAL('0)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .limWrData(limWrData),
    .reqPc(reqPc), .rdAddr(rdAddr), .pgmAddr(pgmAddr), .memRdData(memRdData),
    .limValue(limValue), .pcLow(pcLow), .rdLow(rdLow), .pgmLow(pgmLow),
    .rdData(rdData), .rdValid(rdValid), .accessViol(accessViol),
    .pgmGrant(pgmGrant)
  );

endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk #(
  parameter int ADDR_W = 17,
  parameter int LIMIT_W = 8,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               limWrEn,
  input logic [LIMIT_W-1:0] limWrData,
  input logic [LIMIT_W-1:0] limValue,
  input logic               limLocked,
  input logic [ADDR_W-1:0]  reqPc,
  input logic               rdReq,
  input logic               rdFetch,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [DATA_W-1:0]  memRdData,
  input logic [DATA_W-1:0]  rdData,
  input logic               rdValid,
  input logic               pgmReq,
  input logic [ADDR_W-1:0]  pgmAddr,
  input logic               pgmGrant,
  input logic               accessViol
);

  localparam int PAGE_W = ADDR_W - LIMIT_W;

  logic [ADDR_W-1:0] edgeAddr;
  logic pcOpen, rdProt, pgmProt;

  assign edgeAddr = {limValue, {PAGE_W{1'b0}}};
  assign pcOpen   = reqPc >= edgeAddr;
  assign rdProt   = rdAddr < edgeAddr;
  assign pgmProt  = pgmAddr < edgeAddr;

  // R2
  first_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limWrEn && !limLocked) |=> (limLocked && limValue == $past(limWrData)));

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    limLocked |=> (limLocked && $stable(limValue)));

  // R5
  read_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdFetch && pcOpen && rdProt) |=> (rdValid && rdData == '0 && accessViol));

  // R8
  fetch_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdFetch) |=> (rdData == $past(memRdData)));

  // R9
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  // R9
  read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  // R10
  pgm_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgmReq && pcOpen && pgmProt) |=> (!pgmGrant && accessViol));

  // R10
  pgm_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pgmReq |=> !pgmGrant);

endmodule

bind pmem_partition_guard pmem_guard_chk #(
  .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/test_pmem_partition_guard.sv
module test_pmem_partition_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        limWrEn = 1'b0;
  logic [7:0]  limWrData = '0;
  logic [7:0]  limValue;
  logic        limLocked;
  logic [16:0] reqPc = '0;
  logic        rdReq = 1'b0;
  logic        rdFetch = 1'b0;
  logic [16:0] rdAddr = '0;
  logic [7:0]  memRdData = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        pgmReq = 1'b0;
  logic [16:0] pgmAddr = '0;
  logic        pgmGrant;
  logic        accessViol;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pmem_partition_guard i_pmem_partition_guard (
    .clk(clk), .rstN(rstN), .limWrEn(limWrEn), .limWrData(limWrData),
    .limValue(limValue), .limLocked(limLocked), .reqPc(reqPc), .rdReq(rdReq),
    .rdFetch(rdFetch), .rdAddr(rdAddr), .memRdData(memRdData), .rdData(rdData),
    .rdValid(rdValid), .pgmReq(pgmReq), .pgmAddr(pgmAddr), .pgmGrant(pgmGrant),
    .accessViol(accessViol)
  );

  function automatic logic [7:0] flashByte(int a);
    logic [16:0] v;
    v = 17'(a);
    return v[7:0] ^ v[15:8] ^ {v[16], 7'd0} ^ 8'h5A;
  endfunction

  task automatic chk(string req, int got, int exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeLimit(int v);
    limWrEn = 1'b1;
    limWrData = 8'(v);
    @(negedge clk);
    limWrEn = 1'b0;
  endtask

  // One read request; the result is checked in the following cycle.
  task automatic doRead(int lim, int pc, int addr, bit fetch);
    bit viol;
    string tag;
    reqPc = 17'(pc);
    rdAddr = 17'(addr);
    rdFetch = fetch;
    memRdData = flashByte(addr);
    rdReq = 1'b1;
    viol = !fetch && (pc >= lim * 512) && (addr < lim * 512);
    if (fetch) tag = "R8";
    else if (lim == 0) tag = "R11";
    else if (viol) tag = "R5";
    else if (pc < lim * 512) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    rdReq = 1'b0;
    chk("R9 rdValid", int'(rdValid), 1);
    chk(tag, int'(rdData), viol ? 0 : int'(flashByte(addr)));
    chk({tag, " accessViol"}, int'(accessViol), int'(viol));
  endtask

  task automatic doPgm(int lim, int pc, int addr);
    bit blk;
    reqPc = 17'(pc);
    pgmAddr = 17'(addr);
    pgmReq = 1'b1;
    blk = (pc >= lim * 512) && (addr < lim * 512);
    @(negedge clk);
    pgmReq = 1'b0;
    chk("R10 pgmGrant", int'(pgmGrant), int'(!blk));
    chk("R10 accessViol", int'(accessViol), int'(blk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int limits[6] = '{8'h01, 8'h02, 8'h40, 8'h7F, 8'hA5, 8'hFF};
    doReset();
    // R1 reset state
    chk("R1 limValue", int'(limValue), 0);
    chk("R1 limLocked", int'(limLocked), 0);
    chk("R1 rdValid", int'(rdValid), 0);
    chk("R1 accessViol", int'(accessViol), 0);
    chk("R1 pgmGrant", int'(pgmGrant), 0);

    // R11: the reset limit of zero leaves everything readable.
    for (int p = 0; p < 256; p += 9)
      for (int a = 0; a < 256; a += 11)
        doRead(0, p * 512 + (p * 7 % 512), a * 512 + (a * 13 % 512), 1'b0);

    foreach (limits[k]) begin
      int lim = limits[k];
      int edgeA = lim * 512;
      doReset();
      // R3: a fresh reset re-arms the write.
      chk("R3 rearm limLocked", int'(limLocked), 0);
      writeLimit(lim);
      chk("R2 limValue", int'(limValue), lim);
      chk("R2 limLocked", int'(limLocked), 1);
      writeLimit(lim ^ 8'h3C);
      chk("R3 ignored limValue", int'(limValue), lim);
      chk("R3 limLocked", int'(limLocked), 1);
      writeLimit(0);
      chk("R3 ignored zero", int'(limValue), lim);

      // R4: region edge probes on both addresses.
      doRead(lim, edgeA, edgeA - 1, 1'b0);
      doRead(lim, edgeA, edgeA, 1'b0);
      doRead(lim, edgeA - 1, edgeA - 1, 1'b0);
      doRead(lim, edgeA - 1, edgeA, 1'b0);
      if (lim != 255) doRead(lim, 131071, edgeA - 1, 1'b0);
      doRead(lim, 131071, 0, 1'b0);
      doPgm(lim, edgeA, edgeA - 1);
      doPgm(lim, edgeA, edgeA);
      doPgm(lim, edgeA - 1, edgeA - 1);

      for (int p = 0; p < 256; p += 5)
        for (int a = 0; a < 256; a += 5)
          doRead(lim, p * 512 + (p * 37 % 512), a * 512 + ((a * 11 + p) % 512), 1'b0);

      for (int p = 0; p < 256; p += 17)
        for (int a = 0; a < 256; a += 13) begin
          doRead(lim, p * 512 + 3, a * 512 + 100, 1'b1);
          doPgm(lim, p * 512 + 5, a * 512 + 200);
        end

      // R9: one idle cycle clears the valid and the violation outputs.
      @(negedge clk);
      chk("R9 idle rdValid", int'(rdValid), 0);
      chk("R10 idle pgmGrant", int'(pgmGrant), 0);
      chk("R5 idle accessViol", int'(accessViol), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule